// File: doc/BRIEF.md
# SDRAM Timing Parameter Selector

This block merges the timing data of several memory modules into a single controller timing word. A batch begins with a start pulse that carries a mask of the usable module slots. The block then accepts one record per slot over a valid/ready handshake, in slot order starting at slot 0. A record for a slot outside the mask is consumed and discarded.

For the usable modules, the block keeps a CAS latency set that every module supports at a 133 MHz bus clock. It also tracks the slowest row-precharge time, the slowest RAS-to-CAS delay and the slowest active-to-precharge time. After the last record, each worst-case value is converted into a clock count by fixed threshold comparisons. The block picks a CAS latency, derives the read/write turnaround fields from it, and presents the packed word together with a one-cycle done pulse. An error flag replaces the word when no shared CAS latency exists or when a delay is too long for the supported clock counts.

A firmware-style sequencer or a boot engine would feed this block with bytes already fetched from the module EEPROMs. It then writes the resulting word into the memory controller's timing register.

Top module: `sdram_timing_sel`

## Requirements
- R1: After reset, done, err, rec_ready and every timing bit are 0.
- R2: A start pulse while idle captures usable. rec_ready is high only while records are being collected, and exactly N_DIMM records are taken, slot 0 first. done is a one-cycle pulse that rises on the second clock edge after the handshake of the last record. rec_valid while idle is ignored.
- R3: A record for a slot whose usable bit is 0 has no effect on err or timing.
- R4: In rec_cas, bit 2 means CAS 2.0 and bit 3 means CAS 2.5, and bit 7 is ignored. Let h be the highest set bit among bits 6:0. Bit h is dropped when rec_tck_a > 0x75, bit h-1 is dropped when rec_tck_b > 0x75, and bit h-2 is dropped when rec_tck_c > 0x75. The system set starts as {bit 2, bit 3}, and each usable record's pruned set is ANDed into it.
- R5: If CAS 2.0 remains, timing[8] is 0. Otherwise, if 2.5 remains, timing[8] is 1. If neither remains, err is 1.
- R6: The worst rec_trp (0.25 ns units) over usable slots maps to timing[1:0] = clocks-2. The rules are: above 120 is an error, above 90 gives 4 clocks, above 60 gives 3 clocks, and otherwise 2 clocks.
- R7: The worst rec_trcd maps into timing[3:2] with the same thresholds and encoding as R6.
- R8: The worst rec_tras (whole ns) maps to timing[5:4] = clocks-5. The rules are: above 60 is an error, above 52 gives 8 clocks, above 45 gives 7, above 37 gives 6, and otherwise 5.
- R9: Without error, timing[25] is 1, and timing[27:26] and timing[29:28] each hold 2 for CAS 2.0 and 1 for CAS 2.5. All bits not named in R5 to R9 are 0.
- R10: When err is 1 at done, timing is all zeros.
- R11: A start with usable all zero gives done and err on the next edge, with timing zero, and no record is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a batch (taken while idle) |
| usable | input | N_DIMM | Usable-slot mask for the batch |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Record accepted this cycle when valid |
| rec_cas | input | 8 | Accepted CAS latency bitmask |
| rec_tck_a | input | 8 | Cycle time at the highest CAS |
| rec_tck_b | input | 8 | Cycle time at the next lower CAS |
| rec_tck_c | input | 8 | Cycle time two steps below the highest CAS |
| rec_trp | input | 8 | Row precharge time, 0.25 ns units |
| rec_trcd | input | 8 | RAS-to-CAS delay, 0.25 ns units |
| rec_tras | input | 8 | Active-to-precharge time, ns |
| done | output | 1 | One-cycle result pulse |
| err | output | 1 | Parameters cannot be met |
| timing | output | WORD_W | Packed controller timing word |

## Verification
The bench uses the default of two slots and a 32-bit word. With two slots, every usable mask can be covered, including the empty mask, a single slot with a hostile record in the other slot, and both slots competing for the worst case. The bench sweeps each delay byte across every threshold and into the error zone. It runs all 128 accepted-CAS bitmasks against all eight combinations of cycle-time bytes on either side of 0x75.

// File: rtl/sdram_tsel_pkg.sv
package sdram_tsel_pkg;
  // Timing word field positions
  localparam int F_TRP     = 0;   // 2 bits, clocks-2
  localparam int F_TRCD    = 2;   // 2 bits, clocks-2
  localparam int F_TRAS    = 4;   // 2 bits, clocks-5
  localparam int F_CAS     = 8;   // 0 = 2.0, 1 = 2.5
  localparam int F_RR      = 25;  // fixed one
  localparam int F_RW      = 26;  // 2 bits turnaround
  localparam int F_WR      = 28;  // 2 bits turnaround
  // CAS bitmask positions
  localparam int CAS20_BIT = 2;
  localparam int CAS25_BIT = 3;
  // Longest cycle time usable at 133 MHz
  localparam logic [7:0] TCK_LIMIT = 8'h75;

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_FINISH} tsel_state_t;
endpackage

// File: rtl/tsel_cas_prune.sv
module tsel_cas_prune #(
  parameter int CAS_BITS = 7
) (
  input  logic [7:0]          accept,
  input  logic [7:0]          tck_a,
  input  logic [7:0]          tck_b,
  input  logic [7:0]          tck_c,
  output logic [CAS_BITS-1:0] pruned
);
  import sdram_tsel_pkg::*;

  int   top;
  logic found;

  always_comb begin
    top   = 0;
    found = 1'b0;
    for (int i = 0; i < CAS_BITS; i++) begin
      if (accept[i]) begin
        top   = i;
        found = 1'b1;
      end
    end
    pruned = accept[CAS_BITS-1:0];
    for (int i = 0; i < CAS_BITS; i++) begin
      if (found && (i == top)     && (tck_a > TCK_LIMIT)) pruned[i] = 1'b0;
      if (found && (i == top - 1) && (tck_b > TCK_LIMIT)) pruned[i] = 1'b0;
      if (found && (i == top - 2) && (tck_c > TCK_LIMIT)) pruned[i] = 1'b0;
    end
  end
endmodule

// File: rtl/tsel_quant.sv
module tsel_quant #(
  parameter int             NT      = 2,
  parameter logic [NT*8-1:0] THR     = '0,
  parameter logic [7:0]     ERR_THR = 8'hFF
) (
  input  logic [7:0]                 value,
  output logic [$clog2(NT+1)-1:0]    code,
  output logic                       over
);
  localparam int CW = $clog2(NT+1);

  always_comb begin
    code = '0;
    for (int i = 0; i < NT; i++) begin
      if (value > THR[i*8 +: 8]) code = code + CW'(1);
    end
    over = (value > ERR_THR);
  end
endmodule

// File: rtl/sdram_timing_sel.sv
module sdram_timing_sel #(
  parameter int N_DIMM   = 2,
  parameter int CAS_BITS = 7,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_DIMM-1:0] usable,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [7:0]        rec_cas,
  input  logic [7:0]        rec_tck_a,
  input  logic [7:0]        rec_tck_b,
  input  logic [7:0]        rec_tck_c,
  input  logic [7:0]        rec_trp,
  input  logic [7:0]        rec_trcd,
  input  logic [7:0]        rec_tras,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] timing
);
  import sdram_tsel_pkg::*;

  localparam int SLOT_W = (N_DIMM > 1) ? $clog2(N_DIMM) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_DIMM - 1);
  localparam logic [CAS_BITS-1:0] CAS_INIT =
    CAS_BITS'((1 << CAS20_BIT) | (1 << CAS25_BIT));

  tsel_state_t         state;
  logic [N_DIMM-1:0]   mask_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [CAS_BITS-1:0] sys_cas;
  logic [7:0]          worst_q [3];   // 0: row precharge, 1: ras-to-cas, 2: active time
  logic                idle;
  logic                take;
  logic [CAS_BITS-1:0] rec_pruned;
  logic [7:0]          rec_val [3];

  assign idle      = (state == ST_IDLE);
  assign rec_ready = (state == ST_COLLECT);
  assign take      = rec_valid && rec_ready;
  assign rec_val[0] = rec_trp;
  assign rec_val[1] = rec_trcd;
  assign rec_val[2] = rec_tras;

  tsel_cas_prune #(.CAS_BITS(CAS_BITS)) u_prune (
    .accept (rec_cas),
    .tck_a  (rec_tck_a),
    .tck_b  (rec_tck_b),
    .tck_c  (rec_tck_c),
    .pruned (rec_pruned)
  );

  // Clock-count quantizers: two 0.25 ns delays share thresholds
  logic [1:0] q_code [3];
  logic       q_over [3];

  for (genvar g = 0; g < 2; g++) begin : g_qtr
    tsel_quant #(.NT(2), .THR({8'd90, 8'd60}), .ERR_THR(8'd120)) u_q (
      .value (worst_q[g]),
      .code  (q_code[g]),
      .over  (q_over[g])
    );
  end

  tsel_quant #(.NT(3), .THR({8'd52, 8'd45, 8'd37}), .ERR_THR(8'd60)) u_q_ras (
    .value (worst_q[2]),
    .code  (q_code[2]),
    .over  (q_over[2])
  );

  logic              cas20, cas25, fin_err;
  logic [1:0]        turn;
  logic [WORD_W-1:0] fin_word;

  always_comb begin
    cas20   = sys_cas[CAS20_BIT];
    cas25   = sys_cas[CAS25_BIT];
    fin_err = !(cas20 || cas25) || q_over[0] || q_over[1] || q_over[2];
    turn    = cas20 ? 2'd2 : 2'd1;
    fin_word = '0;
    fin_word[F_TRP  +: 2] = q_code[0];
    fin_word[F_TRCD +: 2] = q_code[1];
    fin_word[F_TRAS +: 2] = q_code[2];
    fin_word[F_CAS]       = !cas20;
    fin_word[F_RR]        = 1'b1;
    fin_word[F_RW   +: 2] = turn;
    fin_word[F_WR   +: 2] = turn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mask_q  <= '0;
      slot_q  <= '0;
      sys_cas <= CAS_INIT;
      for (int k = 0; k < 3; k++) worst_q[k] <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      timing  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mask_q  <= usable;
            slot_q  <= '0;
            sys_cas <= CAS_INIT;
            for (int k = 0; k < 3; k++) worst_q[k] <= '0;
            if (usable == '0) begin
              done   <= 1'b1;
              err    <= 1'b1;
              timing <= '0;
            end else begin
              state <= ST_COLLECT;
            end
          end
        end
        ST_COLLECT: begin
          if (take) begin
            if (mask_q[slot_q]) begin
              sys_cas <= sys_cas & rec_pruned;
              for (int k = 0; k < 3; k++)
                if (rec_val[k] > worst_q[k]) worst_q[k] <= rec_val[k];
            end
            if (slot_q == LAST_SLOT) state <= ST_FINISH;
            else slot_q <= slot_q + SLOT_W'(1);
          end
        end
        default: begin
          done   <= 1'b1;
          err    <= fin_err;
          timing <= fin_err ? '0 : fin_word;
          state  <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int N_DIMM = 2,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [N_DIMM-1:0] usable,
  input logic              rec_ready,
  input logic              done,
  input logic              err,
  input logic [WORD_W-1:0] timing,
  input logic              idle
);
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_no_request_at_done_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !rec_ready);

  p_empty_mask_r11: assert property (@(posedge clk) disable iff (rst)
    (idle && start && usable == '0) |=> (done && err && timing == '0 && !rec_ready));

  p_err_word_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (timing == '0));

  p_fixed_fields_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (timing[25] && timing[27:26] == timing[29:28]));

  p_cas_turn_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (timing[27:26] == (timing[8] ? 2'd1 : 2'd2)));

  p_trp_code_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (timing[1:0] != 2'd3));

  p_trcd_code_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (timing[3:2] != 2'd3));
endmodule

bind sdram_timing_sel tsel_checker #(.N_DIMM(N_DIMM), .WORD_W(WORD_W)) u_tsel_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .usable    (usable),
  .rec_ready (rec_ready),
  .done      (done),
  .err       (err),
  .timing    (timing),
  .idle      (idle)
);

// File: tb/test_sdram_timing_sel.sv
module test_sdram_timing_sel;
  typedef struct {
    int cas, ta, tb, tc, trp, trcd, tras;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  usable = '0;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [7:0]  rec_cas = '0, rec_tck_a = '0, rec_tck_b = '0, rec_tck_c = '0;
  logic [7:0]  rec_trp = '0, rec_trcd = '0, rec_tras = '0;
  logic        done, err;
  logic [31:0] timing;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdram_timing_sel #(.N_DIMM(2), .CAS_BITS(7), .WORD_W(32)) i_sdram_timing_sel (
    .clk(clk), .rst(rst), .start(start), .usable(usable),
    .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_cas(rec_cas), .rec_tck_a(rec_tck_a), .rec_tck_b(rec_tck_b), .rec_tck_c(rec_tck_c),
    .rec_trp(rec_trp), .rec_trcd(rec_trcd), .rec_tras(rec_tras),
    .done(done), .err(err), .timing(timing)
  );

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int clk_of(input int v, input int t0, input int t1, input int t2);
    int c = 0;
    if (v > t0) c++;
    if (v > t1) c++;
    if (v > t2) c++;
    return c;
  endfunction

  // returns {err, word}
  function automatic logic [32:0] model(input logic [1:0] m, input rec_t r0, input rec_t r1);
    int sys = 'hC;
    int wrp = 0, wrcd = 0, wras = 0;
    rec_t r;
    int c, h, tt;
    logic e;
    logic [31:0] w;
    for (int i = 0; i < 2; i++) begin
      if (m[i]) begin
        r = (i == 0) ? r0 : r1;
        c = r.cas & 'h7f;
        h = -1;
        for (int b = 0; b < 7; b++) if ((c >> b) & 1) h = b;
        if (h >= 0 && r.ta > 'h75) c &= ~(1 << h);
        if (h >= 1 && r.tb > 'h75) c &= ~(1 << (h - 1));
        if (h >= 2 && r.tc > 'h75) c &= ~(1 << (h - 2));
        sys &= c;
        if (r.trp > wrp) wrp = r.trp;
        if (r.trcd > wrcd) wrcd = r.trcd;
        if (r.tras > wras) wras = r.tras;
      end
    end
    e = (m == 0) || ((sys & 'hC) == 0) || wrp > 120 || wrcd > 120 || wras > 60;
    if (e) return {1'b1, 32'h0};
    tt = ((sys & 4) != 0) ? 2 : 1;
    w = 32'(clk_of(wrp, 60, 90, 1000)) | 32'(clk_of(wrcd, 60, 90, 1000) << 2)
      | 32'(clk_of(wras, 37, 45, 52) << 4) | 32'(((sys & 4) == 0) ? 256 : 0)
      | 32'(1 << 25) | 32'(tt << 26) | 32'(tt << 28);
    return {1'b0, w};
  endfunction

  task automatic drive_rec(input rec_t r);
    rec_cas = 8'(r.cas); rec_tck_a = 8'(r.ta); rec_tck_b = 8'(r.tb); rec_tck_c = 8'(r.tc);
    rec_trp = 8'(r.trp); rec_trcd = 8'(r.trcd); rec_tras = 8'(r.tras);
  endtask

  task automatic run(input logic [1:0] m, input rec_t r0, input rec_t r1, input string req);
    logic [32:0] exp;
    logic        early;
    exp = model(m, r0, r1);
    @(negedge clk); start = 1'b1; usable = m;
    @(negedge clk); start = 1'b0;
    if (m == 0) begin
      check(done && !rec_ready && {err, timing} == exp, req, {err, timing}, exp);
      return;
    end
    drive_rec(r0); rec_valid = 1'b1;
    @(negedge clk); drive_rec(r1);
    @(negedge clk); rec_valid = 1'b0; early = done;
    @(negedge clk);
    check(!early && done && {err, timing} == exp, req, {err, timing}, exp);
  endtask

  rec_t good, bad, a, b;

  initial begin
    good = '{cas: 'h0C, ta: 'h60, tb: 'h60, tc: 'h60, trp: 60, trcd: 60, tras: 40};
    bad  = '{cas: 'h00, ta: 'hFF, tb: 'hFF, tc: 'hFF, trp: 255, trcd: 255, tras: 255};
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !err && !rec_ready && timing == 0, "R1", {err, timing}, 33'h0);
    rst = 1'b0;
    // R2 record ignored while idle
    @(negedge clk); rec_valid = 1'b1; drive_rec(good);
    @(negedge clk);
    check(!rec_ready && !done, "R2 idle valid", {32'h0, rec_ready}, 33'h0);
    rec_valid = 1'b0;
    // R11 empty mask
    run(2'b00, good, good, "R11");
    // R6 and R3: slot 0 sweeps precharge, slot 1 hostile but masked
    for (int v = 0; v <= 130; v++) begin
      a = good; a.trp = v;
      run(2'b01, a, bad, "R6/R3/R10");
    end
    // R7 and R3: slot 1 only
    for (int v = 0; v <= 130; v++) begin
      a = good; a.trcd = v;
      run(2'b10, bad, a, "R7/R3/R10");
    end
    // R8: both slots, worst active time
    for (int v = 0; v <= 70; v++) begin
      a = good; a.tras = v;
      run(2'b11, a, good, "R8/R10");
    end
    // R6 worst case over two slots
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        int pts[6] = '{50, 61, 90, 91, 120, 121};
        a = good; b = good; a.trp = pts[i]; b.trp = pts[j];
        run(2'b11, a, b, "R6 worst");
      end
    end
    // R4, R5, R9: all CAS bitmasks against all cycle-time combinations
    for (int cs = 0; cs < 256; cs += 1) begin
      for (int k = 0; k < 8; k++) begin
        if (cs < 128 || k == 0) begin
          a = good; a.cas = cs;
          a.ta = k[0] ? 'h76 : 'h75;
          a.tb = k[1] ? 'h80 : 'h40;
          a.tc = k[2] ? 'h90 : 'h10;
          run(2'b01, a, bad, "R4/R5/R9");
        end
      end
    end
    // R4 intersection across two slots
    a = good; a.cas = 'h04; b = good; b.cas = 'h08;
    run(2'b11, a, b, "R4 disjoint");
    a.cas = 'h0C; b.cas = 'h1C; b.ta = 'h80;
    run(2'b11, a, b, "R4/R5 pair");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule